// File: doc/BRIEF.md
# Command and Status Register Bank

This block is the host-visible register file of a packet-processing unit. A host addresses it with byte addresses. Each register takes a 16-byte slot, so the register number is the address divided by 16. Only the lowest 32-bit word of a slot holds data. The low four address bits are ignored. A read request returns registered data on the next cycle.

The bank has these registers:
- a status word of flags;
- a partly writable error-mask word;
- a mark register;
- a write-only command register;
- a group of configuration and state registers that the host can only read. The unit's core loads these through a separate port that has one strobe per register.

Five of the registers exist only when the build parameter `VARIANT` is 1. These are the base, offset, double-buffer tops, top and buffer-select registers.

A command write has up to four effects, applied from least to most overriding: status-clear, stop request, force-break, then unit reset. Writing the mark register also clears the mark-detected status flag. A host write that the bank refuses produces a one-cycle error pulse.

Top module: `bank_regs`

## Requirements
- R1: The register index is `host_addr_i[11:4]`, and bits 3:0 have no effect. A read returns the register on `host_rdata_o` one cycle after the request. In any cycle that follows no read, `host_rdata_o` is zero.
- R2: Indices 4–10 (cycle, mode, count, mask, code, interrupt-tops, interrupt-top) and 16–23 (R0–R3 then C0–C3), and index 0 (status), are read-only from the host. A host write to one of them leaves it unchanged and raises `host_werr_o` for the one following cycle.
- R3: Indices 11–15 (base, offset, double-buffer tops, top, buffer-select) are present only when `VARIANT`=1. When `VARIANT`=0, reads of them return zero and core loads to them are dropped. In both variants a host write to them is refused with `host_werr_o`.
- R4: The command register (index 1) always reads as zero. A write to it never raises `host_werr_o`.
- R5: Command bit 0 (status-clear) zeroes these status bits: stall-pending (bit 0), forced-break (bit 1), interrupt-stall (bit 2), interrupt (bit 3), error-0 (bit 4), error-1 (bit 5), and the pending-stop bit (bit 7). Mark-detected (bit 6) is kept.
- R6: Command bit 1 (stop) sets the pending-stop status bit 7 and changes nothing else.
- R7: Command bit 2 (force-break) sets status bit 1. When both clear and stop are set in one write, bit 7 ends at 1. When both clear and force-break are set, bit 1 ends at 1.
- R8: Command bit 3 (reset) zeroes every register and pulses `unit_rst_o` for one cycle. This happens whatever other command bits are set in the same write.
- R9: A write to the error-mask register (index 2) replaces bits 2:0 only. Bits 31:3 keep their values.
- R10: A write to the mark register (index 3) loads `wdata[15:0]`, reads back with bits 31:16 zero, and clears status bit 6.
- R11: `core_we_i[i]` loads `core_wdata_i` into register i. The status register keeps bits 7:0 and the mark register keeps bits 15:0. Strobes for the command register have no effect. When the host changes a status flag in the same cycle as a core load of the status register, the host change wins.
- R12: Indices 24 and above read as zero, and writes to them raise `host_werr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_en_i | input | 1 | Host access request |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | ADDR_W | Byte address relative to bank base |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Registered read data |
| host_werr_o | output | 1 | One-cycle pulse after a refused write |
| core_we_i | input | 24 | Per-register load strobes from the core |
| core_wdata_i | input | 32 | Core load data |
| unit_rst_o | output | 1 | One-cycle pulse after a reset command |

## Verification
Two copies of the bank run side by side on the same stimulus, one per variant, so every access to the variant-only slots shows the difference between the builds.

Directed cases cover the following:
- every single command bit, and the paired clear+stop and clear+break writes, starting from an all-ones status word, which separates the evaluation order from a plain OR;
- an error-mask write over a core-loaded all-ones word, which shows whether the upper bits are preserved;
- a mark write while the mark flag is set;
- the same-cycle conflict between a core status load and a host clear;
- unmapped slots.

Random traffic then mixes reads, refused writes, commands and sparse core strobes across all slots. This exposes interactions that the directed cases do not order.

// File: rtl/bank_regs_pkg.sv
package bank_regs_pkg;
    localparam int DW   = 32;
    localparam int NREG = 24;
    localparam int IW   = 5;

    localparam int IDX_STAT  = 0;
    localparam int IDX_CMD   = 1;
    localparam int IDX_ERRM  = 2;
    localparam int IDX_MARK  = 3;
    localparam int IDX_V1_LO = 11;
    localparam int IDX_V1_HI = 15;

    localparam int ERRM_W = 3;
    localparam int MARK_W = 16;
    localparam int STAT_W = 8;

    // status flag positions
    localparam int ST_STALL   = 0;
    localparam int ST_FBRK    = 1;
    localparam int ST_ISTALL  = 2;
    localparam int ST_IRQ     = 3;
    localparam int ST_ERR0    = 4;
    localparam int ST_ERR1    = 5;
    localparam int ST_MARK    = 6;
    localparam int ST_STOPREQ = 7;

    // command bit positions, least to most overriding
    localparam int C_CLR  = 0;
    localparam int C_STOP = 1;
    localparam int C_BRK  = 2;
    localparam int C_RST  = 3;

    typedef logic [NREG-1:0][DW-1:0] bank_t;

    function automatic logic [DW-1:0] clr_mask();
        logic [DW-1:0] m;
        m = '0;
        m[ST_STALL]   = 1'b1;
        m[ST_FBRK]    = 1'b1;
        m[ST_ISTALL]  = 1'b1;
        m[ST_IRQ]     = 1'b1;
        m[ST_ERR0]    = 1'b1;
        m[ST_ERR1]    = 1'b1;
        m[ST_STOPREQ] = 1'b1;
        return m;
    endfunction

    function automatic logic [DW-1:0] reg_mask(int i);
        if (i == IDX_STAT) return DW'((64'd1 << STAT_W) - 1);
        if (i == IDX_MARK) return DW'((64'd1 << MARK_W) - 1);
        if (i == IDX_CMD)  return '0;
        return '1;
    endfunction

    function automatic logic present(int variant, int i);
        return (variant == 1) || (i < IDX_V1_LO) || (i > IDX_V1_HI);
    endfunction
endpackage

// File: rtl/bank_decode.sv
module bank_decode
    import bank_regs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IW-1:0]     idx,
    output logic              is_cmd,
    output logic              is_errm,
    output logic              is_mark
);
    localparam int SW = ADDR_W - 4;

    logic [SW-1:0] slot;
    assign slot = addr[ADDR_W-1:4];

    always_comb begin
        hit     = (slot < SW'(NREG));
        idx     = slot[IW-1:0];
        is_cmd  = hit && (idx == IW'(IDX_CMD));
        is_errm = hit && (idx == IW'(IDX_ERRM));
        is_mark = hit && (idx == IW'(IDX_MARK));
    end
endmodule

// File: rtl/bank_core_merge.sv
module bank_core_merge
    import bank_regs_pkg::*;
#(
    parameter int VARIANT = 1
) (
    input  bank_t           cur,
    input  logic [NREG-1:0] we,
    input  logic [DW-1:0]   data,
    output bank_t           nxt
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (present(VARIANT, i) && i != IDX_CMD) begin : g_live
            assign nxt[i] = we[i] ? (data & reg_mask(i)) : cur[i];
        end else begin : g_dead
            assign nxt[i] = '0;
        end
    end
endmodule

// File: rtl/bank_read_mux.sv
module bank_read_mux
    import bank_regs_pkg::*;
#(
    parameter int VARIANT = 1
) (
    input  bank_t         regs,
    input  logic          hit,
    input  logic [IW-1:0] idx,
    output logic [DW-1:0] val
);
    always_comb begin
        val = '0;
        if (hit && present(VARIANT, int'(idx)) && idx != IW'(IDX_CMD))
            val = regs[idx];
    end
endmodule

// File: rtl/bank_regs.sv
module bank_regs
    import bank_regs_pkg::*;
#(
    parameter int VARIANT = 1,
    parameter int ADDR_W  = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              host_en_i,
    input  logic              host_we_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [DW-1:0]     host_wdata_i,
    output logic [DW-1:0]     host_rdata_o,
    output logic              host_werr_o,
    input  logic [NREG-1:0]   core_we_i,
    input  logic [DW-1:0]     core_wdata_i,
    output logic              unit_rst_o
);
    localparam logic [DW-1:0] CLR_BITS = clr_mask();

    typedef struct packed {
        bank_t         regs;
        logic [DW-1:0] rdata;
        logic          werr;
        logic          urst;
    } state_t;

    state_t        st_d, st_q;
    logic          hit, is_cmd, is_errm, is_mark;
    logic [IW-1:0] idx;
    bank_t         merged;
    logic [DW-1:0] rd_val;

    bank_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (host_addr_i),
        .hit     (hit),
        .idx     (idx),
        .is_cmd  (is_cmd),
        .is_errm (is_errm),
        .is_mark (is_mark)
    );

    bank_core_merge #(.VARIANT(VARIANT)) u_merge (
        .cur  (st_q.regs),
        .we   (core_we_i),
        .data (core_wdata_i),
        .nxt  (merged)
    );

    bank_read_mux #(.VARIANT(VARIANT)) u_rmux (
        .regs (st_q.regs),
        .hit  (hit),
        .idx  (idx),
        .val  (rd_val)
    );

    always_comb begin
        st_d       = st_q;
        st_d.regs  = merged;
        st_d.rdata = '0;
        st_d.werr  = 1'b0;
        st_d.urst  = 1'b0;
        if (host_en_i && !host_we_i) begin
            st_d.rdata = rd_val;
        end
        if (host_en_i && host_we_i) begin
            if (is_cmd) begin
                if (host_wdata_i[C_CLR])
                    st_d.regs[IDX_STAT] = st_d.regs[IDX_STAT] & ~CLR_BITS;
                if (host_wdata_i[C_STOP])
                    st_d.regs[IDX_STAT][ST_STOPREQ] = 1'b1;
                if (host_wdata_i[C_BRK])
                    st_d.regs[IDX_STAT][ST_FBRK] = 1'b1;
                if (host_wdata_i[C_RST]) begin
                    st_d.regs = '0;
                    st_d.urst = 1'b1;
                end
            end else if (is_errm) begin
                st_d.regs[IDX_ERRM][ERRM_W-1:0] = host_wdata_i[ERRM_W-1:0];
            end else if (is_mark) begin
                st_d.regs[IDX_MARK] = {{(DW-MARK_W){1'b0}}, host_wdata_i[MARK_W-1:0]};
                st_d.regs[IDX_STAT][ST_MARK] = 1'b0;
            end else begin
                st_d.werr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign host_rdata_o = st_q.rdata;
    assign host_werr_o  = st_q.werr;
    assign unit_rst_o   = st_q.urst;
endmodule

// File: rtl/bank_regs_chk.sv
module bank_regs_chk
    import bank_regs_pkg::*;
#(
    parameter int VARIANT = 1,
    parameter int ADDR_W  = 12
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              host_en_i,
    input logic              host_we_i,
    input logic [ADDR_W-1:0] host_addr_i,
    input logic [DW-1:0]     host_wdata_i,
    input logic [DW-1:0]     host_rdata_o,
    input logic              host_werr_o,
    input logic              unit_rst_o
);
    localparam int SW = ADDR_W - 4;

    logic [SW-1:0] slot;
    logic          wr, rd;
    assign slot = host_addr_i[ADDR_W-1:4];
    assign wr   = host_en_i && host_we_i;
    assign rd   = host_en_i && !host_we_i;

    p_idle_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd |=> host_rdata_o == '0);

    p_ro_write_err_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr && slot >= SW'(4) && slot < SW'(NREG) |=> host_werr_o);

    p_v0_hidden_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (VARIANT == 0) && rd && slot >= SW'(IDX_V1_LO) && slot <= SW'(IDX_V1_HI)
        |=> host_rdata_o == '0);

    p_cmd_reads_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd && slot == SW'(IDX_CMD) |=> host_rdata_o == '0);

    p_cmd_no_err_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr && slot == SW'(IDX_CMD) |=> !host_werr_o);

    p_rst_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr && slot == SW'(IDX_CMD) && host_wdata_i[C_RST] |=> unit_rst_o);

    p_no_spurious_rst_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr && slot == SW'(IDX_CMD) && host_wdata_i[C_RST]) |=> !unit_rst_o);

    p_unmapped_err_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr && slot >= SW'(NREG) |=> host_werr_o);
endmodule

bind bank_regs bank_regs_chk #(.VARIANT(VARIANT), .ADDR_W(ADDR_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_en_i    (host_en_i),
    .host_we_i    (host_we_i),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (host_rdata_o),
    .host_werr_o  (host_werr_o),
    .unit_rst_o   (unit_rst_o)
);

// File: tb/bank_regs_test.sv
module bank_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_en = 1'b0, host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [23:0] core_we = '0;
    logic [31:0] core_wdata = '0;
    logic [31:0] rdata1, rdata0;
    logic        werr1, werr0, urst1, urst0;

    int vectors = 0;
    int fails   = 0;
    logic [31:0] m [2][24];

    always #5 clk = ~clk;

    bank_regs #(.VARIANT(1), .ADDR_W(12)) uut (
        .clk_i(clk), .rst_ni(rst_n), .host_en_i(host_en), .host_we_i(host_we),
        .host_addr_i(host_addr), .host_wdata_i(host_wdata), .host_rdata_o(rdata1),
        .host_werr_o(werr1), .core_we_i(core_we), .core_wdata_i(core_wdata),
        .unit_rst_o(urst1));

    bank_regs #(.VARIANT(0), .ADDR_W(12)) uut0 (
        .clk_i(clk), .rst_ni(rst_n), .host_en_i(host_en), .host_we_i(host_we),
        .host_addr_i(host_addr), .host_wdata_i(host_wdata), .host_rdata_o(rdata0),
        .host_werr_o(werr0), .core_we_i(core_we), .core_wdata_i(core_wdata),
        .unit_rst_o(urst0));

    function automatic logic [31:0] wmask(int r);
        if (r == 0) return 32'h0000_00FF;
        if (r == 3) return 32'h0000_FFFF;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic bit exists(int v, int r);
        return v == 1 || r < 11 || r > 15;
    endfunction

    task automatic apply(input logic en, input logic we, input logic [11:0] a,
                         input logic [31:0] wd, input logic [23:0] cwe,
                         input logic [31:0] cd, input string tag);
        logic [31:0] erd [2];
        logic        eerr [2];
        logic        eurst [2];
        logic [31:0] ard, aerr, aurst;
        int idx;
        idx = int'(a[11:4]);
        host_en = en; host_we = we; host_addr = a; host_wdata = wd;
        core_we = cwe; core_wdata = cd;
        for (int v = 0; v < 2; v++) begin
            erd[v] = '0; eerr[v] = 1'b0; eurst[v] = 1'b0;
            if (en && !we && idx < 24 && idx != 1 && exists(v, idx)) erd[v] = m[v][idx];
            for (int r = 0; r < 24; r++)
                if (cwe[r] && r != 1 && exists(v, r)) m[v][r] = cd & wmask(r);
            if (en && we) begin
                case (idx)
                    1: begin
                        if (wd[0]) m[v][0] = m[v][0] & ~32'h0000_00BF;
                        if (wd[1]) m[v][0][7] = 1'b1;
                        if (wd[2]) m[v][0][1] = 1'b1;
                        if (wd[3]) begin
                            for (int r = 0; r < 24; r++) m[v][r] = '0;
                            eurst[v] = 1'b1;
                        end
                    end
                    2: m[v][2][2:0] = wd[2:0];
                    3: begin
                        m[v][3] = {16'h0, wd[15:0]};
                        m[v][0][6] = 1'b0;
                    end
                    default: eerr[v] = 1'b1;
                endcase
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int v = 0; v < 2; v++) begin
            ard   = v ? rdata1 : rdata0;
            aerr  = v ? 32'(werr1) : 32'(werr0);
            aurst = v ? 32'(urst1) : 32'(urst0);
            vectors++;
            if (ard !== erd[v] || aerr !== 32'(eerr[v]) || aurst !== 32'(eurst[v])) begin
                fails++;
                $display("FAIL %s variant%0d idx=%0d: rdata=%h werr=%0d urst=%0d, expected rdata=%h werr=%0d urst=%0d",
                         tag, v, idx, ard, aerr, aurst, erd[v], eerr[v], eurst[v]);
            end
        end
        host_en = 1'b0; core_we = '0;
    endtask

    task automatic hrd(input int idx, input string tag);
        apply(1'b1, 1'b0, {8'(idx), 4'h0}, '0, '0, '0, tag);
        apply(1'b0, 1'b0, '0, '0, '0, '0, tag);
    endtask

    task automatic hwr(input int idx, input logic [31:0] d, input string tag);
        apply(1'b1, 1'b1, {8'(idx), 4'h0}, d, '0, '0, tag);
    endtask

    task automatic cld(input int idx, input logic [31:0] d, input string tag);
        apply(1'b0, 1'b0, '0, '0, 24'(1) << idx, d, tag);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
    end

    initial begin
        int idx;
        logic [31:0] wd;
        string tg;
        void'($urandom(32'd7));
        for (int v = 0; v < 2; v++) for (int r = 0; r < 24; r++) m[v][r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state, slot addressing with low bits set
        for (int r = 0; r < 26; r++) hrd(r, "R1");
        apply(1'b1, 1'b0, 12'h00B, '0, '0, '0, "R1");

        // core loads of every loadable slot, then readback
        for (int r = 4; r < 24; r++) cld(r, 32'hA500_0000 | r, "R11");
        for (int r = 4; r < 24; r++) hrd(r, "R3");
        apply(1'b1, 1'b0, 12'h0C7, '0, '0, '0, "R1");

        // refused writes
        hwr(4, 32'h1234_5678, "R2");  hrd(4, "R2");
        hwr(0, 32'hFFFF_FFFF, "R2");  hrd(0, "R2");
        hwr(19, 32'h0, "R2");         hrd(19, "R2");
        hwr(12, 32'hDEAD_BEEF, "R3"); hrd(12, "R3");
        hwr(24, 32'h1, "R12");        hwr(200, 32'h1, "R12"); hrd(30, "R12");

        // command register
        hwr(1, 32'h0, "R4"); hrd(1, "R4");
        cld(0, 32'hFF, "R5"); hwr(1, 32'h1, "R5"); hrd(0, "R5");
        hwr(1, 32'h2, "R6"); hrd(0, "R6");
        cld(0, 32'hFF, "R7"); hwr(1, 32'h5, "R7"); hrd(0, "R7");
        cld(0, 32'hFF, "R7"); hwr(1, 32'h3, "R7"); hrd(0, "R7");
        cld(0, 32'h0, "R7");  hwr(1, 32'h4, "R7"); hrd(0, "R7");

        // error mask and mark
        cld(2, 32'hFFFF_FFF0, "R9"); hwr(2, 32'h0000_000D, "R9"); hrd(2, "R9");
        hwr(2, 32'h8000_0002, "R9"); hrd(2, "R9");
        cld(0, 32'h40, "R10"); hwr(3, 32'h1234_ABCD, "R10"); hrd(3, "R10"); hrd(0, "R10");

        // same-cycle core load and host command
        apply(1'b1, 1'b1, 12'h010, 32'h1, 24'h1, 32'hFF, "R11"); hrd(0, "R11");
        apply(1'b1, 1'b1, 12'h030, 32'h7, 24'h1, 32'h7F, "R11"); hrd(0, "R11");
        apply(1'b1, 1'b1, 12'h010, 32'h0, 24'h2, 32'hFFFF, "R11"); hrd(1, "R11");

        // reset command overrides the rest
        hwr(1, 32'hF, "R8");
        for (int r = 0; r < 24; r++) hrd(r, "R8");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            idx = int'($urandom % 27);
            wd  = $urandom;
            if (idx == 1) wd = wd & ((($urandom % 16) == 0) ? 32'hF : 32'h7);
            case (idx)
                1: tg = "R5"; 2: tg = "R9"; 3: tg = "R10";
                default: tg = "R2";
            endcase
            case ($urandom % 4)
                0: apply(1'b1, 1'b0, {8'(idx), 4'($urandom)}, '0, '0, '0, "R1");
                1: apply(1'b1, 1'b1, {8'(idx), 4'($urandom)}, wd, '0, '0, tg);
                2: apply(1'b0, 1'b0, '0, '0, 24'($urandom & $urandom & $urandom), $urandom, "R11");
                default: apply(1'b1, 1'b1, {8'(idx), 4'h0}, wd,
                               24'($urandom & $urandom), $urandom, "R11");
            endcase
        end
        for (int r = 0; r < 26; r++) hrd(r, "R1");
        summary();
    end
endmodule